// File: doc/BRIEF.md
# MAC Table Aging Scanner

This block keeps an internal table of MAC address entries and walks through it slowly, one entry at a time, to remove stale entries. Each entry holds a valid bit, a "hit" bit and a MAC address. The learning logic installs or refreshes an entry through a refresh port. A refresh writes the MAC address and sets both the valid and hit bits. When the scanner visits a valid entry whose hit bit is set, it clears the hit bit. When it visits a valid entry whose hit bit is already clear, it invalidates the entry and issues a delete notification to the CPU side. The notification carries the entry index and the MAC address.

The sweep rate comes from a 16-bit aging value held in two byte registers. A prescaler makes a base tick every `TICK_CYCLES` clocks. The default is `CLK_HZ/1250`, which is one tick per 800 µs. The scanner moves on by one entry each time the aging value's worth of ticks has built up. One full pass therefore lasts aging value × entries × 800 µs. With the defaults (0x005C, 4096 entries) that is about 300 s.

The notification port is valid/ready. Once `note_valid` rises, it stays high and `note_idx`/`note_mac` hold steady until a cycle in which `note_ready` is high; `note_valid` falls on the following edge. While a notification is waiting, the scanner takes no step and ticks are not accumulated. No deletion is ever dropped or skipped.

Top module: `age_sweeper`

## Requirements
- R1: The aging value is `{high byte, low byte}`. A write with `reg_sel`=0 targets the low byte and `reg_sel`=1 targets the high byte. The write is stored at the clock edge. `reg_rdata` combinationally shows the byte that `reg_sel` selects.
- R2: After reset the low byte is 0x5C and the high byte is 0x00. The scan index is 0, every entry is invalid and `note_valid` is 0.
- R3: A base tick occurs every `TICK_CYCLES` clocks. The scanner steps once per aging value ticks, so one pass lasts aging value × `ENTRIES` × `TICK_CYCLES` clocks.
- R4: An aging value of 0 stops all steps, clears the tick accumulator and produces no notifications.
- R5: A step onto a valid entry with hit=1 clears hit. The entry is kept and no notification is produced.
- R6: A step onto a valid entry with hit=0 invalidates it. `note_valid` rises on the next edge, with `note_idx` equal to the visited index and `note_mac` equal to its stored address.
- R7: Each step advances the scan index by one, wrapping from `ENTRIES-1` to 0. Invalid entries are passed over with no action.
- R8: A refresh (`ref_valid`=1) writes `ref_mac` into entry `ref_idx` and sets valid=1 and hit=1. If a step visits that same index in the same cycle, the refresh takes effect, the scanner does nothing to the entry, and the index still advances.
- R9: While `note_valid`=1 and `note_ready`=0, `note_valid`, `note_idx` and `note_mac` hold. No step happens while `note_valid`=1.
- R10: A write to either aging byte changes the step rate from the next step on. It does not reset the scan index or the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the aging byte selected by `reg_sel` |
| reg_sel | input | 1 | 0 = low aging byte, 1 = high aging byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected aging byte |
| ref_valid | input | 1 | Refresh/install strobe from learning |
| ref_idx | input | IDX_W | Entry index to refresh |
| ref_mac | input | 48 | MAC address stored with the refresh |
| note_valid | output | 1 | Delete notification pending |
| note_ready | input | 1 | CPU side accepts the notification |
| note_idx | output | IDX_W | Index of the deleted entry |
| note_mac | output | 48 | MAC address of the deleted entry |

## Verification
A register write shows on `reg_rdata` after the edge that stores it. A step taken at an edge raises `note_valid` at that same edge, which is one edge after the prescaler's last count. A notification accepted at an edge clears `note_valid` at that edge. The bench holds a behavioural model that updates at each rising edge from the inputs the bench drove at the previous falling edge. At every falling edge it compares `note_valid`, `note_idx`, `note_mac` and `reg_rdata` with the model, so each result is checked in the first cycle it is due. Targeted sequences add explicit tallies of deletions per index, covering the refresh collision, the stall, the disabled mode and a rate change in mid-pass.

// File: rtl/age_pkg.sv
package age_pkg;
  localparam int MAC_W = 48;
  typedef logic [MAC_W-1:0] mac_t;
  localparam logic [7:0] AGE_LO_RST = 8'h5C;
  localparam logic [7:0] AGE_HI_RST = 8'h00;
  typedef enum logic {SEL_AGE_LO = 1'b0, SEL_AGE_HI = 1'b1} age_sel_e;
endpackage

// File: rtl/age_tick_gen.sv
module age_tick_gen #(
  parameter int unsigned TICK_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  generate
    if (TICK_CYCLES <= 1) begin : g_every_clk
      assign tick = 1'b1;
    end else begin : g_counter
      localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/age_step_timer.sv
module age_step_timer #(
  parameter int AGE_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             hold,
  input  logic [AGE_W-1:0] age_val,
  output logic             step
);
  logic [AGE_W-1:0] acc;
  logic [AGE_W:0]   acc_inc;

  assign acc_inc = {1'b0, acc} + 1'b1;
  // step once the tick about to be counted completes the aging value
  assign step = tick && !hold && (age_val != '0) && (acc_inc >= {1'b0, age_val});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               acc <= '0;
    else if (age_val == '0)   acc <= '0;
    else if (tick && !hold)   acc <= step ? '0 : acc_inc[AGE_W-1:0];
  end
endmodule

// File: rtl/age_scan_table.sv
module age_scan_table
  import age_pkg::*;
#(
  parameter int ENTRIES = 4096,
  parameter int IDX_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  mac_t             ref_mac,
  input  logic             note_ready,
  output logic             note_valid,
  output logic [IDX_W-1:0] note_idx,
  output mac_t             note_mac,
  output logic [IDX_W-1:0] scan_idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] hit;
  mac_t               mac_mem [ENTRIES];

  logic             cur_v, cur_h, collide, act, do_del, do_clr;
  logic [IDX_W-1:0] idx_next;

  assign cur_v    = vld[scan_idx];
  assign cur_h    = hit[scan_idx];
  assign collide  = ref_valid && (ref_idx == scan_idx);
  assign act      = step && !collide;
  assign do_del   = act && cur_v && !cur_h;
  assign do_clr   = act && cur_v && cur_h;
  assign idx_next = (scan_idx == LAST) ? '0 : scan_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      hit <= '0;
    end else begin
      if (do_clr) hit[scan_idx] <= 1'b0;
      if (do_del) vld[scan_idx] <= 1'b0;
      if (ref_valid) begin
        vld[ref_idx] <= 1'b1;
        hit[ref_idx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ref_valid) mac_mem[ref_idx] <= ref_mac;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    scan_idx <= '0;
    else if (step) scan_idx <= idx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      note_valid <= 1'b0;
      note_idx   <= '0;
      note_mac   <= '0;
    end else if (do_del) begin
      note_valid <= 1'b1;
      note_idx   <= scan_idx;
      note_mac   <= mac_mem[scan_idx];
    end else if (note_valid && note_ready) begin
      note_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/age_sweeper.sv
module age_sweeper
  import age_pkg::*;
#(
  parameter int          ENTRIES     = 4096,
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned TICK_CYCLES = CLK_HZ / 1250,
  localparam int         IDX_W       = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ref_valid,
  input  logic [IDX_W-1:0] ref_idx,
  input  logic [MAC_W-1:0] ref_mac,
  output logic             note_valid,
  input  logic             note_ready,
  output logic [IDX_W-1:0] note_idx,
  output logic [MAC_W-1:0] note_mac
);
  logic [7:0]       age_lo, age_hi;
  logic [15:0]      age_val;
  logic             tick, step;
  logic [IDX_W-1:0] scan_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_lo <= AGE_LO_RST;
      age_hi <= AGE_HI_RST;
    end else if (reg_wr) begin
      if (age_sel_e'(reg_sel) == SEL_AGE_HI) age_hi <= reg_wdata;
      else                                   age_lo <= reg_wdata;
    end
  end

  assign age_val   = {age_hi, age_lo};
  assign reg_rdata = (age_sel_e'(reg_sel) == SEL_AGE_HI) ? age_hi : age_lo;

  age_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  age_step_timer #(.AGE_W(16)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hold(note_valid),
    .age_val(age_val), .step(step)
  );

  age_scan_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .step(step),
    .ref_valid(ref_valid), .ref_idx(ref_idx), .ref_mac(ref_mac),
    .note_ready(note_ready), .note_valid(note_valid),
    .note_idx(note_idx), .note_mac(note_mac), .scan_idx(scan_idx)
  );
endmodule

// File: rtl/age_sweeper_chk.sv
module age_sweeper_chk #(
  parameter int ENTRIES = 4096,
  parameter int IDX_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             step,
  input logic [15:0]      age_val,
  input logic [IDX_W-1:0] scan_idx,
  input logic             note_valid,
  input logic             note_ready,
  input logic [IDX_W-1:0] note_idx,
  input logic [47:0]      note_mac
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  a_r3_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> tick);

  a_r4_no_step_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (age_val == 16'd0) |-> !step);

  a_r6_note_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(note_valid) |-> ($past(step) && note_idx == $past(scan_idx)));

  a_r7_index_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step && scan_idx == LAST) |=> (scan_idx == '0));

  a_r9_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (note_valid && !note_ready) |=> (note_valid && $stable(note_idx) && $stable(note_mac)));

  a_r9_no_step_pending: assert property (@(posedge clk) disable iff (!rst_n)
    note_valid |-> !step);
endmodule

bind age_sweeper age_sweeper_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .step(step), .age_val(age_val),
  .scan_idx(scan_idx), .note_valid(note_valid), .note_ready(note_ready),
  .note_idx(note_idx), .note_mac(note_mac)
);

// File: tb/test_age_sweeper.sv
module test_age_sweeper;
  localparam int N    = 16;
  localparam int TICK = 4;
  localparam int IW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_sel = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic          ref_valid = 1'b0;
  logic [IW-1:0] ref_idx = '0;
  logic [47:0]   ref_mac = '0;
  logic          note_valid, note_ready = 1'b1;
  logic [IW-1:0] note_idx;
  logic [47:0]   note_mac;

  always #10 clk = ~clk;

  age_sweeper #(.ENTRIES(N), .CLK_HZ(5000), .TICK_CYCLES(TICK)) i_age_sweeper (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_valid(ref_valid),
    .ref_idx(ref_idx), .ref_mac(ref_mac), .note_valid(note_valid),
    .note_ready(note_ready), .note_idx(note_idx), .note_mac(note_mac)
  );

  int checks = 0, fails = 0;
  int dut_del = 0, mdl_del = 0;
  int del_cnt [N];

  // behavioural reference model
  int          m_pc, m_acc, m_idx, m_nidx;
  bit          m_v [N];
  bit          m_h [N];
  logic [47:0] m_mac [N];
  bit          m_nv;
  logic [47:0] m_nmac;
  logic [7:0]  m_lo, m_hi;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_acc = 0; m_idx = 0; m_nv = 0; m_nidx = 0; m_nmac = '0;
      m_lo = 8'h5C; m_hi = 8'h00;
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_h[i] = 0; end
    end else begin
      int  age;
      bit  tk, stp;
      age = {m_hi, m_lo};
      tk  = (m_pc == TICK - 1);
      stp = tk && !m_nv && age != 0 && (m_acc + 1 >= age);
      if (age == 0) m_acc = 0;
      else if (tk && !m_nv) m_acc = stp ? 0 : m_acc + 1;
      m_pc = tk ? 0 : m_pc + 1;
      if (m_nv && note_ready) m_nv = 0;
      if (stp) begin
        if (!(ref_valid && int'(ref_idx) == m_idx)) begin
          if (m_v[m_idx] && m_h[m_idx]) m_h[m_idx] = 0;
          else if (m_v[m_idx]) begin
            m_v[m_idx] = 0; m_nv = 1; m_nidx = m_idx; m_nmac = m_mac[m_idx];
          end
        end
        m_idx = (m_idx + 1) % N;
      end
      if (ref_valid) begin
        m_v[ref_idx] = 1; m_h[ref_idx] = 1; m_mac[ref_idx] = ref_mac;
      end
      if (reg_wr) begin
        if (reg_sel) m_hi = reg_wdata; else m_lo = reg_wdata;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    check(note_valid === m_nv, "R6 R9 note_valid", 64'(note_valid), 64'(m_nv));
    if (m_nv) begin
      check(int'(note_idx) == m_nidx, "R7 note_idx", 64'(note_idx), 64'(m_nidx));
      check(note_mac === m_nmac, "R8 note_mac", note_mac, m_nmac);
    end
    check(reg_rdata === (reg_sel ? m_hi : m_lo), "R1 reg_rdata", 64'(reg_rdata),
          64'(reg_sel ? m_hi : m_lo));
    if (note_valid && note_ready) begin dut_del++; del_cnt[note_idx]++; end
    if (m_nv && note_ready) mdl_del++;
  endtask

  task automatic wr_reg(input bit sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic install(input int i, input logic [47:0] mac);
    ref_valid = 1'b1; ref_idx = IW'(i); ref_mac = mac;
    cyc();
    ref_valid = 1'b0;
  endtask

  function automatic bit step_next();
    int age;
    age = {m_hi, m_lo};
    return (m_pc == TICK - 1) && !m_nv && age != 0 && (m_acc + 1 >= age);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base, visits;
    logic [15:0] lfsr;
    for (int i = 0; i < N; i++) del_cnt[i] = 0;
    repeat (3) cyc();
    check(note_valid === 1'b0, "R2 note_valid in reset", 64'(note_valid), 0);
    rst_n = 1'b1;
    reg_sel = 1'b0; cyc();
    check(reg_rdata == 8'h5C, "R2 low default", 64'(reg_rdata), 64'h5C);
    reg_sel = 1'b1; cyc();
    check(reg_rdata == 8'h00, "R2 high default", 64'(reg_rdata), 64'h00);

    // R3: one step per tick, entries visited in order
    wr_reg(1'b0, 8'd1);
    install(3, 48'h0011_2233_4403);
    install(5, 48'h0011_2233_4405);
    install(9, 48'h0011_2233_4409);
    install(12, 48'h0011_2233_440C);
    for (int c = 0; c < 200; c++) begin
      if (c % 30 == 0) begin
        ref_valid = 1'b1; ref_idx = IW'(5); ref_mac = 48'h0011_2233_4405;
      end
      cyc();
      ref_valid = 1'b0;
    end
    check(del_cnt[5] == 0, "R5 refreshed entry kept", 64'(del_cnt[5]), 0);
    check(del_cnt[3] == 1, "R6 stale entry deleted once", 64'(del_cnt[3]), 1);
    check(del_cnt[12] == 1, "R7 entry near wrap deleted", 64'(del_cnt[12]), 1);

    // R8: refresh coinciding with the second visit keeps the entry
    install(7, 48'hA5A5_0000_0007);
    visits = 0;
    for (int c = 0; c < 400 && visits < 2; c++) begin
      if (step_next() && m_idx == 7) begin
        visits++;
        if (visits == 2) begin
          ref_valid = 1'b1; ref_idx = IW'(7); ref_mac = 48'hA5A5_0000_0077;
        end
      end
      cyc();
      ref_valid = 1'b0;
    end
    repeat (8) cyc();
    check(del_cnt[7] == 0, "R8 collision refresh wins", 64'(del_cnt[7]), 0);

    // R9: back-pressure stall
    install(0, 48'hBEEF_0000_0000);
    install(1, 48'hBEEF_0000_0001);
    install(2, 48'hBEEF_0000_0002);
    note_ready = 1'b0;
    repeat (300) cyc();
    check(note_valid === 1'b1, "R9 notification held", 64'(note_valid), 1);
    base = dut_del;
    note_ready = 1'b1;
    repeat (200) cyc();
    check(dut_del - base >= 3, "R9 no deletion skipped", 64'(dut_del - base), 3);

    // R4: aging disabled
    wr_reg(1'b0, 8'd0);
    install(4, 48'hCAFE_0000_0004);
    base = dut_del;
    repeat (300) cyc();
    check(dut_del == base, "R4 no deletions when off", 64'(dut_del), 64'(base));

    // R1 / R10: high byte, then rate change mid-pass
    wr_reg(1'b1, 8'h01);
    reg_sel = 1'b1; cyc();
    check(reg_rdata == 8'h01, "R1 high byte readback", 64'(reg_rdata), 1);
    repeat (300) cyc();
    wr_reg(1'b1, 8'h00);
    wr_reg(1'b0, 8'd3);
    repeat (500) cyc();
    check(dut_del == mdl_del, "R10 deletions after rate change", 64'(dut_del), 64'(mdl_del));

    // mixed traffic
    wr_reg(1'b0, 8'd1);
    lfsr = 16'hACE1;
    for (int c = 0; c < 3000; c++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ref_valid  = (lfsr[3:0] == 4'h0);
      ref_idx    = lfsr[7:4];
      ref_mac    = {32'h1234_5678, lfsr};
      note_ready = lfsr[9] | lfsr[11];
      cyc();
    end
    ref_valid = 1'b0; note_ready = 1'b1;
    repeat (50) cyc();
    check(dut_del == mdl_del, "R3 total deletions", 64'(dut_del), 64'(mdl_del));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule